// File: doc/BRIEF.md
# Pulsed Doppler Burst Timing Controller

This block sets the transmit-side timing of a pulsed Doppler front end. Each repetition period begins with a window in which the transmitter is enabled. During that window a programmable number of carrier-rate pulses is sent. While the transmitter is active, a gate keeps the receiver input closed. After the window closes, a programmable delay runs and then a single-cycle strobe starts the converter. Two square references at the carrier frequency, a quarter cycle apart, feed the quadrature mixers.

The host writes a set of control fields through a one-cycle write strobe:
- carrier select,
- pulses per burst,
- repetition terminal value,
- acquisition delay,
- continuous-transmission flag.

These values are held as pending. The block applies them only at the next period boundary, so a running period always finishes with the values it started with.

The repetition interval comes from two cascaded counters. An 8-bit prescaler with a fixed terminal value steps a 16-bit counter. The 16-bit counter's terminal value is programmable and has a default that is loaded at reset. The carrier is produced by a clock-enable divider that ticks at four times the carrier rate and steps a 2-bit Johnson counter. The divider has two settings, one for each carrier choice.

Top module: `pdop_burst_ctrl`

## Requirements
- R1: While reset is high, the outputs are idle: tx_en, burst, acq_start, prf_tick, ref_i and ref_q are 0, and rx_gate is 1. Reset loads the default field values into both the pending and the active set. The period that follows reset uses those defaults.
- R2: A period lasts (PRE_LAST+1)*(rep+1) clock cycles, where rep is the active 16-bit terminal value. prf_tick is 1 in the first cycle of every period and 0 otherwise.
- R3: Let D be the quarter-carrier divisor: DIV_FAST when the carrier-select field is 1, DIV_SLOW when it is 0. Both references are 0 in the first cycle of a period. ref_i first rises D cycles into the period and ref_q first rises 2D cycles into it. Each reference repeats every 4D cycles, and ref_q lags ref_i by a quarter cycle.
- R4: With the continuous flag 0 and N>0 pulses, tx_en is 1 from the first cycle of the period for 4*N*D cycles. burst equals tx_en AND ref_i, so it shows exactly N pulses.
- R5: rx_gate is 0 exactly when tx_en is 1 and the continuous flag is 0. Otherwise it is 1.
- R6: With the continuous flag 1, tx_en stays 1 for the whole period, burst follows ref_i, and rx_gate stays 1.
- R7: acq_start is a single-cycle pulse at cycle 4*N*D + delay + 1 of the period, counted from 0. In continuous mode N counts as 0. The pulse is dropped if that cycle falls outside the period.
- R8: A pulse count of 0 with the continuous flag 0 keeps tx_en and burst at 0. The period timing, the references and acq_start (at cycle delay + 1) carry on as usual.
- R9: A write with cfg_wr in the middle of a period leaves that period unchanged. The written values take effect from the next period start, and tx_en can only rise in a cycle where prf_tick is 1.
- R10: If a burst would run past the end of its period, the period boundary takes priority. tx_en stays 1 up to the boundary, the new period starts a fresh burst, and no acq_start is issued for the truncated burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | One-cycle strobe that captures the cfg_* fields as pending values |
| cfg_fast | input | 1 | Carrier select: 1 = higher carrier (DIV_FAST), 0 = lower (DIV_SLOW) |
| cfg_pulses | input | 8 | Carrier pulses per burst |
| cfg_rep | input | 16 | Terminal value of the repetition counter |
| cfg_delay | input | 16 | Cycles between the end of the burst and the acquisition strobe |
| cfg_cont | input | 1 | Continuous-transmission flag |
| tx_en | output | 1 | Transmitter enable window |
| burst | output | 1 | Carrier pulses gated by tx_en |
| rx_gate | output | 1 | Receiver gate, 1 = receiver open |
| ref_i | output | 1 | In-phase carrier reference |
| ref_q | output | 1 | Quadrature reference, lags ref_i by 90 degrees |
| acq_start | output | 1 | Single-cycle converter start strobe |
| prf_tick | output | 1 | First cycle of each repetition period |

## Verification
The hardest case to reach is a burst whose last carrier cycle ends on the same clock edge as the period wrap. On that edge both the end-of-burst update and the reload compete, and the reload must win. The stimulus reaches it by choosing a pulse count and terminal value whose products are equal, so 4*N*D equals the period length. A second delicate case is a host write that lands in the middle of a period. The bench issues every new field set five cycles into the period it is measuring. It then checks that the window, pulse count, strobe position and quadrature phases of that period still match the old set, and that the next period matches the new one.

// File: rtl/pdop_pkg.sv
package pdop_pkg;
  localparam int PULSE_W = 8;
  localparam int REP_W   = 16;
  localparam int DLY_W   = 16;
  localparam int PRE_W   = 8;

  typedef struct packed {
    logic               fast;
    logic               cont;
    logic [PULSE_W-1:0] pulses;
    logic [REP_W-1:0]   rep;
    logic [DLY_W-1:0]   dly;
  } pdop_cfg_t;
endpackage

// File: rtl/pdop_rep_timer.sv
module pdop_rep_timer #(
  parameter int PRE_W    = 8,
  parameter int PRE_LAST = 255,
  parameter int REP_W    = 16,
  parameter int REP_RST  = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REP_W-1:0] rep_lim,
  output logic             wrap
);
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(PRE_LAST);

  logic [PRE_W-1:0] pre_cnt;
  logic [REP_W-1:0] rep_cnt;

  assign wrap = (pre_cnt == PRE_TOP) && (rep_cnt == rep_lim);

  // Reset parks the counters on the last cycle of a period.
  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= PRE_TOP;
      rep_cnt <= REP_W'(REP_RST);
    end else if (wrap) begin
      pre_cnt <= '0;
      rep_cnt <= '0;
    end else if (pre_cnt == PRE_TOP) begin
      pre_cnt <= '0;
      rep_cnt <= rep_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pdop_quad_gen.sv
module pdop_quad_gen #(
  parameter int DIV_FAST = 3,
  parameter int DIV_SLOW = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic fast,
  output logic ref_i,
  output logic ref_q,
  output logic cyc_done
);
  localparam int DMAX = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
  localparam int QW   = (DMAX > 1) ? $clog2(DMAX) : 1;

  logic [QW-1:0] qd_cnt;
  logic [QW-1:0] qd_last;
  logic [1:0]    jq;
  logic          tick;

  assign qd_last  = fast ? QW'(DIV_FAST - 1) : QW'(DIV_SLOW - 1);
  assign tick     = (qd_cnt == qd_last);
  assign cyc_done = tick && (jq == 2'b10);
  assign ref_i    = jq[0];
  assign ref_q    = jq[1];

  // Johnson sequence 00 -> 01 -> 11 -> 10, one step per quarter tick.
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      qd_cnt <= '0;
      jq     <= 2'b00;
    end else begin
      qd_cnt <= tick ? '0 : qd_cnt + 1'b1;
      if (tick) jq <= {jq[0], ~jq[1]};
    end
  end
endmodule

// File: rtl/pdop_burst_seq.sv
module pdop_burst_seq
  import pdop_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wrap,
  input  logic               cyc_done,
  input  logic [PULSE_W-1:0] nxt_pulses,
  input  logic               nxt_cont,
  input  logic               act_cont,
  input  logic [DLY_W-1:0]   act_dly,
  output logic               tx_en,
  output logic               rx_open,
  output logic               acq
);
  logic [PULSE_W-1:0] left;
  logic               armed;
  logic [DLY_W-1:0]   dcnt;
  logic               start_tx;

  assign start_tx = nxt_cont || (nxt_pulses != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      left    <= '0;
      tx_en   <= 1'b0;
      rx_open <= 1'b1;
      armed   <= 1'b0;
      dcnt    <= '0;
      acq     <= 1'b0;
    end else if (wrap) begin
      left    <= nxt_pulses;
      tx_en   <= start_tx;
      rx_open <= !start_tx || nxt_cont;
      armed   <= !start_tx || nxt_cont;
      dcnt    <= '0;
      acq     <= 1'b0;
    end else begin
      acq <= 1'b0;
      if (tx_en && !act_cont && cyc_done) begin
        left <= left - 1'b1;
        if (left == PULSE_W'(1)) begin
          tx_en   <= 1'b0;
          rx_open <= 1'b1;
          armed   <= 1'b1;
          dcnt    <= '0;
        end
      end
      if (armed) begin
        if (dcnt == act_dly) begin
          acq   <= 1'b1;
          armed <= 1'b0;
        end else begin
          dcnt <= dcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pdop_burst_ctrl.sv
module pdop_burst_ctrl
  import pdop_pkg::*;
#(
  parameter int PRE_LAST   = 255,
  parameter int DIV_FAST   = 3,
  parameter int DIV_SLOW   = 4,
  parameter int DEF_FAST   = 1,
  parameter int DEF_PULSES = 4,
  parameter int DEF_REP    = 1000,
  parameter int DEF_DLY    = 64,
  parameter int DEF_CONT   = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic               cfg_fast,
  input  logic [PULSE_W-1:0] cfg_pulses,
  input  logic [REP_W-1:0]   cfg_rep,
  input  logic [DLY_W-1:0]   cfg_delay,
  input  logic               cfg_cont,
  output logic               tx_en,
  output logic               burst,
  output logic               rx_gate,
  output logic               ref_i,
  output logic               ref_q,
  output logic               acq_start,
  output logic               prf_tick
);
  localparam pdop_cfg_t CFG_DEF = '{
    fast:   1'(DEF_FAST),
    cont:   1'(DEF_CONT),
    pulses: PULSE_W'(DEF_PULSES),
    rep:    REP_W'(DEF_REP),
    dly:    DLY_W'(DEF_DLY)
  };

  pdop_cfg_t pend;
  pdop_cfg_t act;
  logic      wrap;
  logic      cyc_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= CFG_DEF;
      act      <= CFG_DEF;
      prf_tick <= 1'b0;
    end else begin
      if (cfg_wr) begin
        pend <= '{fast: cfg_fast, cont: cfg_cont, pulses: cfg_pulses,
                  rep: cfg_rep, dly: cfg_delay};
      end
      if (wrap) act <= pend;
      prf_tick <= wrap;
    end
  end

  pdop_rep_timer #(
    .PRE_W   (PRE_W),
    .PRE_LAST(PRE_LAST),
    .REP_W   (REP_W),
    .REP_RST (DEF_REP)
  ) u_rep (
    .clk    (clk),
    .rst    (rst),
    .rep_lim(act.rep),
    .wrap   (wrap)
  );

  pdop_quad_gen #(
    .DIV_FAST(DIV_FAST),
    .DIV_SLOW(DIV_SLOW)
  ) u_quad (
    .clk     (clk),
    .rst     (rst),
    .restart (wrap),
    .fast    (act.fast),
    .ref_i   (ref_i),
    .ref_q   (ref_q),
    .cyc_done(cyc_done)
  );

  pdop_burst_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .wrap      (wrap),
    .cyc_done  (cyc_done),
    .nxt_pulses(pend.pulses),
    .nxt_cont  (pend.cont),
    .act_cont  (act.cont),
    .act_dly   (act.dly),
    .tx_en     (tx_en),
    .rx_open   (rx_gate),
    .acq       (acq_start)
  );

  assign burst = tx_en & ref_i;
endmodule

// File: rtl/pdop_burst_ctrl_chk.sv
module pdop_burst_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic burst,
  input logic rx_gate,
  input logic ref_i,
  input logic ref_q,
  input logic acq_start,
  input logic prf_tick
);
  AST_ACQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    acq_start |=> !acq_start); // R7
  AST_GATE_OPEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !tx_en |-> rx_gate); // R5
  AST_BURST_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    burst |-> tx_en); // R4
  AST_TX_RISE_AT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |-> prf_tick); // R9
  AST_REFS_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    prf_tick |-> (!ref_i && !ref_q)); // R3
  AST_REF_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    !prf_tick |-> ($countones({ref_i, ref_q} ^ $past({ref_i, ref_q})) <= 1)); // R3
endmodule

bind pdop_burst_ctrl pdop_burst_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .tx_en    (tx_en),
  .burst    (burst),
  .rx_gate  (rx_gate),
  .ref_i    (ref_i),
  .ref_q    (ref_q),
  .acq_start(acq_start),
  .prf_tick (prf_tick)
);

// File: tb/pdop_burst_ctrl_bench.sv
module pdop_burst_ctrl_bench;
  import pdop_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic cfg_fast = 1'b0;
  logic [PULSE_W-1:0] cfg_pulses = '0;
  logic [REP_W-1:0]   cfg_rep = '0;
  logic [DLY_W-1:0]   cfg_delay = '0;
  logic cfg_cont = 1'b0;
  logic tx_en, burst, rx_gate, ref_i, ref_q, acq_start, prf_tick;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pdop_burst_ctrl #(
    .PRE_LAST(3), .DIV_FAST(3), .DIV_SLOW(4), .DEF_FAST(1),
    .DEF_PULSES(2), .DEF_REP(9), .DEF_DLY(8), .DEF_CONT(0)
  ) u_pdop_burst_ctrl (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_fast(cfg_fast),
    .cfg_pulses(cfg_pulses), .cfg_rep(cfg_rep), .cfg_delay(cfg_delay),
    .cfg_cont(cfg_cont), .tx_en(tx_en), .burst(burst), .rx_gate(rx_gate),
    .ref_i(ref_i), .ref_q(ref_q), .acq_start(acq_start), .prf_tick(prf_tick)
  );

  // kind: 0 plain, 1 zero pulses, 2 continuous, 3 overrun, 4 reset default
  typedef struct packed {
    int fast; int pulses; int rep; int dly; int cont; int kind;
    int len; int tx; int np; int acq; int ri; int rq;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1, 2,  9,  8, 0, 4, 40, 24, 2, 33, 3, 6},
    '{1, 2, 15,  5, 0, 0, 64, 24, 2, 30, 3, 6},
    '{0, 3, 19, 10, 0, 0, 80, 48, 3, 59, 4, 8},
    '{1, 0,  9,  7, 0, 1, 40,  0, 0,  8, 3, 6},
    '{0, 1,  7,  0, 0, 0, 32, 16, 1, 17, 4, 8},
    '{1, 4, 11,  2, 1, 2, 48, 48, 4,  3, 3, 6},
    '{0, 2,  7,  0, 0, 3, 32, 32, 2, -1, 4, 8}
  };

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic string tx_tag(input int kind);
    case (kind)
      1: return "R8 tx window";
      2: return "R6 tx window";
      3: return "R10 tx window";
      4: return "R1 tx window";
      default: return "R4 R9 tx window";
    endcase
  endfunction

  task automatic wait_tick();
    do @(negedge clk); while (!prf_tick);
  endtask

  // Starts at a negedge inside cycle 0 of a period, stops at cycle 0 of the next.
  task automatic measure(input int cont, input bit mid_wr,
                         output int len, output int tx, output int np,
                         output int acq, output int ri, output int rq,
                         output int gerr);
    int k = 0;
    bit pb = 1'b0, pi = 1'b0, pq = 1'b0;
    tx = 0; np = 0; acq = -1; ri = -1; rq = -1; gerr = 0;
    while (1) begin
      if (tx_en) tx++;
      if (burst && !pb) np++;
      if (acq_start) acq = (acq == -1) ? k : -2;
      if (ref_i && !pi && ri < 0) ri = k;
      if (ref_q && !pq && rq < 0) rq = k;
      if (rx_gate != ((cont != 0) || !tx_en)) gerr++;
      pb = burst; pi = ref_i; pq = ref_q;
      cfg_wr = mid_wr && (k == 5);
      k++;
      @(negedge clk);
      if (prf_tick) break;
    end
    cfg_wr = 1'b0;
    len = k;
  endtask

  task automatic run_vec(input vec_t v, input bit mid_wr);
    int len, tx, np, acq, ri, rq, gerr;
    measure(v.cont, mid_wr, len, tx, np, acq, ri, rq, gerr);
    check("R2 period length", len, v.len);
    check(tx_tag(v.kind), tx, v.tx);
    check("R4 pulse count", np, v.np);
    check(v.kind == 1 ? "R8 acq cycle" : "R7 acq cycle", acq, v.acq);
    check("R3 ref_i first rise", ri, v.ri);
    check("R3 ref_q first rise", rq, v.rq);
    check("R5 gate mismatches", gerr, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog: got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 reset outputs",
          {tx_en, burst, rx_gate, ref_i, ref_q, acq_start, prf_tick},
          7'b0010000);
    rst = 1'b0;
    wait_tick();
    for (int i = 0; i < NV; i++) begin
      if (i + 1 < NV) begin
        cfg_fast   = VECS[i+1].fast[0];
        cfg_pulses = PULSE_W'(VECS[i+1].pulses);
        cfg_rep    = REP_W'(VECS[i+1].rep);
        cfg_delay  = DLY_W'(VECS[i+1].dly);
        cfg_cont   = VECS[i+1].cont[0];
      end
      run_vec(VECS[i], i + 1 < NV);
    end
    // R1 reset asserted while a burst is active
    check("R1 tx before mid-run reset", int'(tx_en), 1);
    rst = 1'b1;
    @(negedge clk);
    check("R1 outputs in mid-run reset",
          {tx_en, burst, rx_gate, acq_start, prf_tick}, 5'b00100);
    @(negedge clk);
    rst = 1'b0;
    wait_tick();
    run_vec(VECS[0], 1'b0);
    report();
    $finish;
  end
endmodule